// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block turns service slots into transmit work. An external scheduler hands it one channel number per slot. The block keeps a small state table for each channel, holding an enable bit, an active flag, a 4 KB-aligned ring base and an 8-bit ring index. It uses that table to fetch the descriptor the channel points at from host memory, through a plain 32-bit read port with one read outstanding at a time.

Each descriptor is 16 bytes, read as four little-endian 32-bit words:

- word 0 is the control word, which holds the ownership bit and the length;
- word 1 is the buffer address;
- words 2 and 3 are reserved.

When the device owns the entry, the block reads all four words. It then hands the buffer address and length downstream with a one-cycle strobe and moves the channel to its next entry. When the host still owns the entry, the block stops after the control word and raises a one-cycle idle-cell request instead.

A channel that is disabled, not active, or numbered outside the table is answered with an idle request at once, without any memory access. The host loads a channel's whole entry with a single configuration write.

Top module: `txd_ring_poller`

## Requirements
- R1: After reset `svc_ready` is 1, `desc_valid`, `idle_valid` and `mem_rd_req` are 0, and every channel reads as disabled.
- R2: A read targets the byte address `{base[19:0], index[7:0], word[1:0], 2'b00}`, so the address is always 4-byte aligned.
- R3: For a device-owned entry the block issues exactly four reads, for words 0, 1, 2 and 3 in that order. For a host-owned entry it issues only the read of word 0. No read is issued until the previous one has returned.
- R4: Bit 31 of word 0 set means device-owned. Such an entry yields one `desc_valid` strobe carrying the channel, `desc_buf_addr` equal to word 1 and `desc_len` equal to word 0 bits 15:0.
- R5: Bit 31 of word 0 clear yields one `idle_valid` strobe for the channel and leaves its index unchanged, so the next slot re-reads the same entry.
- R6: A slot for a channel that is disabled, inactive or numbered 255 or above yields `idle_valid` in the cycle after the slot is accepted, with no memory read.
- R7: After a device-owned entry is consumed, the channel's 8-bit index increments and wraps from 255 to 0.
- R8: Every accepted slot produces exactly one strobe, either `desc_valid` or `idle_valid` and never both. `svc_ready` stays low while a fetch is in flight.
- R9: A write with `cfg_we` high to channel c below 255 sets that channel's base, index, enable and active values. When it coincides with an index advance for the same channel, the configuration write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Channel table write strobe |
| cfg_chan | input | 8 | Channel to write |
| cfg_base | input | 20 | Ring base, address bits 31:12 |
| cfg_idx | input | 8 | Ring index to load |
| cfg_enable | input | 1 | Host enable for the channel |
| cfg_active | input | 1 | Channel has queued work |
| svc_req | input | 1 | Service slot for `svc_chan` |
| svc_chan | input | 8 | Channel picked by the scheduler |
| svc_ready | output | 1 | Block can accept a slot |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned word |
| desc_valid | output | 1 | Descriptor strobe |
| desc_chan | output | 8 | Channel of the descriptor |
| desc_buf_addr | output | 32 | Buffer address |
| desc_len | output | 16 | Buffer length |
| idle_valid | output | 1 | Idle-cell request strobe |
| idle_chan | output | 8 | Channel of the idle request |

## Verification
A corrupted ring index or base surfaces on the first read of the channel's next slot, as a wrong `mem_addr` one cycle after the slot is accepted. A wrong ownership decision shows up as a missing or extra read and as the wrong strobe kind, at the latest one memory round trip after the control word returns. Stale enable or active state shows up as a memory read where none was due, or as an idle strobe in place of a fetch. The bench therefore compares every read address and every strobe, cycle by cycle, against a behavioural model of the table.

// File: rtl/txd_ring_poller.sv
module txd_ring_poller #(
  parameter int NCHAN   = 255,
  parameter int CW      = 8,
  parameter int IW      = 8,
  parameter int LW      = 16,
  parameter int OWN_BIT = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CW-1:0]         cfg_chan,
  input  logic [32-IW-5:0]      cfg_base,
  input  logic [IW-1:0]         cfg_idx,
  input  logic                  cfg_enable,
  input  logic                  cfg_active,
  input  logic                  svc_req,
  input  logic [CW-1:0]         svc_chan,
  output logic                  svc_ready,
  output logic                  mem_rd_req,
  output logic [31:0]           mem_addr,
  input  logic                  mem_rd_valid,
  input  logic [31:0]           mem_rd_data,
  output logic                  desc_valid,
  output logic [CW-1:0]         desc_chan,
  output logic [31:0]           desc_buf_addr,
  output logic [LW-1:0]         desc_len,
  output logic                  idle_valid,
  output logic [CW-1:0]         idle_chan
);
  localparam int BW = 32 - IW - 4;
  localparam logic [CW:0] NCH = NCHAN[CW:0];

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_BUF, S_RSV0, S_RSV1} st_t;
  st_t state;

  logic [BW-1:0]    base_q [NCHAN];
  logic [IW-1:0]    idx_q  [NCHAN];
  logic [NCHAN-1:0] en_q, act_q;

  logic [CW-1:0] cur_ch;
  logic [BW-1:0] cur_base;
  logic [IW-1:0] cur_idx;
  logic [LW-1:0] len_q;
  logic [31:0]   buf_q;

  wire          svc_in_range = {1'b0, svc_chan} < NCH;
  wire          cfg_in_range = {1'b0, cfg_chan} < NCH;
  wire [CW-1:0] ch_sel       = svc_in_range ? svc_chan : '0;
  wire          accept       = svc_req && svc_ready;
  wire          fetch_go     = accept && svc_in_range && en_q[ch_sel] && act_q[ch_sel];
  wire          owned        = mem_rd_data[OWN_BIT];

  assign svc_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      mem_rd_req <= 1'b0;
      desc_valid <= 1'b0;
      idle_valid <= 1'b0;
      en_q       <= '0;
      act_q      <= '0;
    end else begin
      mem_rd_req <= 1'b0;
      desc_valid <= 1'b0;
      idle_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (fetch_go) begin
            cur_ch     <= svc_chan;
            cur_base   <= base_q[ch_sel];
            cur_idx    <= idx_q[ch_sel];
            mem_rd_req <= 1'b1;
            mem_addr   <= {base_q[ch_sel], idx_q[ch_sel], 4'h0};
            state      <= S_CTRL;
          end else if (accept) begin
            idle_valid <= 1'b1;
            idle_chan  <= svc_chan;
          end
        end
        S_CTRL: if (mem_rd_valid) begin
          if (owned) begin
            len_q      <= mem_rd_data[LW-1:0];
            mem_rd_req <= 1'b1;
            mem_addr   <= {cur_base, cur_idx, 4'h4};
            state      <= S_BUF;
          end else begin
            idle_valid <= 1'b1;
            idle_chan  <= cur_ch;
            state      <= S_IDLE;
          end
        end
        S_BUF: if (mem_rd_valid) begin
          buf_q      <= mem_rd_data;
          mem_rd_req <= 1'b1;
          mem_addr   <= {cur_base, cur_idx, 4'h8};
          state      <= S_RSV0;
        end
        S_RSV0: if (mem_rd_valid) begin
          mem_rd_req <= 1'b1;
          mem_addr   <= {cur_base, cur_idx, 4'hC};
          state      <= S_RSV1;
        end
        S_RSV1: if (mem_rd_valid) begin
          desc_valid    <= 1'b1;
          desc_chan     <= cur_ch;
          desc_buf_addr <= buf_q;
          desc_len      <= len_q;
          idx_q[cur_ch] <= cur_idx + 1'b1;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (cfg_we && cfg_in_range) begin
        base_q[cfg_chan] <= cfg_base;
        idx_q[cfg_chan]  <= cfg_idx;
        en_q[cfg_chan]   <= cfg_enable;
        act_q[cfg_chan]  <= cfg_active;
      end
    end
  end
endmodule

module txd_ring_poller_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        svc_ready,
  input logic        mem_rd_req,
  input logic [31:0] mem_addr,
  input logic        desc_valid,
  input logic        idle_valid
);
  a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_valid && idle_valid));
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> mem_addr[1:0] == 2'b00);
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
  a_r8_busy_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !svc_ready);
  a_r4_done_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (svc_ready && !mem_rd_req));
endmodule

bind txd_ring_poller txd_ring_poller_sva u_sva (
  .clk(clk), .rst_n(rst_n), .svc_ready(svc_ready), .mem_rd_req(mem_rd_req),
  .mem_addr(mem_addr), .desc_valid(desc_valid), .idle_valid(idle_valid)
);

// File: tb/tb_txd_ring_poller.sv
`timescale 1ns/1ps
module tb_txd_ring_poller;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_enable = 0, cfg_active = 0;
  logic [7:0] cfg_chan = 0, cfg_idx = 0, svc_chan = 0;
  logic [19:0] cfg_base = 0;
  logic svc_req = 0, svc_ready, mem_rd_req, mem_rd_valid = 0;
  logic [31:0] mem_addr, mem_rd_data = 0, desc_buf_addr;
  logic desc_valid, idle_valid;
  logic [7:0] desc_chan, idle_chan;
  logic [15:0] desc_len;

  always #2.5 clk = ~clk;

  txd_ring_poller dut (.*);

  typedef struct packed { logic is_desc; logic [7:0] ch; logic [31:0] ba; logic [15:0] len; } exp_t;
  exp_t        exp_out[$];
  string       exp_tag[$];
  logic [31:0] exp_addr[$];
  logic [31:0] mem[logic [31:0]];
  logic [19:0] m_base[256];
  logic [7:0]  m_idx[256];
  bit          m_en[256], m_act[256];

  int checks = 0, errors = 0, cycles = 0;
  bit pend = 0;
  int cnt = 0, lat = 1;
  logic [31:0] raddr;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // memory responder and cycle-by-cycle monitor
  always @(negedge clk) begin
    cycles++;
    mem_rd_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= rd(raddr);
        pend = 0;
      end else cnt--;
    end
    if (rst_n && mem_rd_req) begin
      if (exp_addr.size() == 0) chk(0, "R6", "unexpected read", mem_addr, 0);
      else begin
        logic [31:0] e;
        e = exp_addr.pop_front();
        chk(mem_addr == e, "R2", "read address", mem_addr, e);
      end
      pend = 1; raddr = mem_addr; cnt = lat;
    end
    if (rst_n && (desc_valid || idle_valid)) begin
      if (exp_out.size() == 0) chk(0, "R8", "unexpected strobe", {desc_valid, idle_valid}, 0);
      else begin
        exp_t  e;
        string t;
        e = exp_out.pop_front();
        t = exp_tag.pop_front();
        chk(desc_valid == e.is_desc && idle_valid == !e.is_desc, t, "strobe kind",
            {desc_valid, idle_valid}, {e.is_desc, !e.is_desc});
        if (e.is_desc)
          chk(desc_chan == e.ch && desc_buf_addr == e.ba && desc_len == e.len, t, "descriptor",
              {desc_chan, desc_buf_addr, desc_len}, {e.ch, e.ba, e.len});
        else
          chk(idle_chan == e.ch, t, "idle channel", idle_chan, e.ch);
      end
    end
  end

  task automatic put_desc(logic [19:0] b, logic [7:0] i, bit own, logic [15:0] len, logic [31:0] ba);
    logic [31:0] a;
    a = {b, i, 4'h0};
    mem[a]      = {own, 15'h1234, len};
    mem[a + 4]  = ba;
    mem[a + 8]  = 32'hDEAD0000 | a;
    mem[a + 12] = 32'hBEEF0000 | a;
  endtask

  task automatic cfg(logic [7:0] ch, logic [19:0] b, logic [7:0] i, bit en, bit act);
    @(negedge clk);
    cfg_we = 1; cfg_chan = ch; cfg_base = b; cfg_idx = i; cfg_enable = en; cfg_active = act;
    @(negedge clk);
    cfg_we = 0;
    if (ch != 8'hFF) begin m_base[ch] = b; m_idx[ch] = i; m_en[ch] = en; m_act[ch] = act; end
  endtask

  task automatic slot(logic [7:0] ch, string tag);
    exp_t e;
    bit   fetch;
    logic [31:0] a, c;
    while (!svc_ready) @(negedge clk);
    fetch = (ch != 8'hFF) && m_en[ch] && m_act[ch];
    e = '0; e.ch = ch;
    if (fetch) begin
      a = {m_base[ch], m_idx[ch], 4'h0};
      c = rd(a);
      exp_addr.push_back(a);
      if (c[31]) begin
        exp_addr.push_back(a + 4); exp_addr.push_back(a + 8); exp_addr.push_back(a + 12);
        e.is_desc = 1; e.ba = rd(a + 4); e.len = c[15:0];
        m_idx[ch] = m_idx[ch] + 8'd1;
      end
    end
    exp_out.push_back(e);
    exp_tag.push_back(tag);
    svc_req = 1; svc_chan = ch;
    @(negedge clk);
    svc_req = 0;
    if (fetch) chk(svc_ready == 0, "R8", "ready low during fetch", svc_ready, 0);
    while (exp_out.size() != 0 || exp_addr.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_en[i] = 0; m_act[i] = 0; m_idx[i] = 0; m_base[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(svc_ready == 1 && desc_valid == 0 && idle_valid == 0 && mem_rd_req == 0, "R1", "reset outputs",
        {svc_ready, desc_valid, idle_valid, mem_rd_req}, 4'b1000);
    slot(8'd3, "R1");
    put_desc(20'h00012, 8'd0, 1, 16'd64, 32'h1000_0040);
    put_desc(20'h00012, 8'd1, 1, 16'd1500, 32'h2000_0000);
    put_desc(20'h00012, 8'd2, 0, 16'd9, 32'h3000_0000);
    cfg(8'd3, 20'h00012, 8'd0, 1, 1);
    lat = 0; slot(8'd3, "R4");
    lat = 2; slot(8'd3, "R3");
    slot(8'd3, "R5");
    lat = 1; slot(8'd3, "R5");
    put_desc(20'h00012, 8'd2, 1, 16'd48, 32'h3000_0100);
    slot(8'd3, "R4");
    put_desc(20'hABCDE, 8'd254, 1, 16'd1, 32'hA000_0001);
    put_desc(20'hABCDE, 8'd255, 1, 16'd2, 32'hA000_0002);
    put_desc(20'hABCDE, 8'd0, 1, 16'd3, 32'hA000_0003);
    cfg(8'd7, 20'hABCDE, 8'd254, 1, 1);
    slot(8'd7, "R7");
    lat = 3; slot(8'd7, "R7");
    lat = 0; slot(8'd7, "R7");
    cfg(8'd9, 20'h00055, 8'd0, 0, 1);
    put_desc(20'h00055, 8'd0, 1, 16'd5, 32'h5500_0000);
    slot(8'd9, "R6");
    cfg(8'd10, 20'h00055, 8'd0, 1, 0);
    slot(8'd10, "R6");
    slot(8'hFF, "R6");
    cfg(8'd9, 20'h00055, 8'd0, 1, 1);
    lat = 1; slot(8'd9, "R9");
    cfg(8'd3, 20'h00012, 8'd1, 1, 1);
    slot(8'd3, "R9");
    slot(8'd7, "R3");
    slot(8'd3, "R5");
    repeat (5) @(negedge clk);
    chk(exp_out.size() == 0 && exp_addr.size() == 0, "R8", "leftover expectations",
        exp_out.size() + exp_addr.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule